// File: doc/BRIEF.md
# Sound Master Control Register Bank

This block holds the top-level controls of a four-channel sound unit. It sits behind a 16-bit peripheral bus that has a write strobe, a write register select, write data and a separate read register select. It stores a master enable, a volume for each side and a per-side enable for each channel, plus a 2-bit gain code for the legacy tone channels. It drives these fields to the channel mixers as decoded control signals. The mixing arithmetic is done elsewhere.

The master enable also gates every other sound register. While it is clear, the only write that takes effect is a write to the master register. Writes to this bank's routing and ratio registers are discarded. The forwarded write strobe that the channel register banks use (`ext_wr_o`) is held low. Stored fields keep their values while the unit is disabled.

Top module: `snd_ctl_bank`

## Requirements
- R1: After reset, all stored fields are zero: master enable off, volumes 0, channel enables 0, ratio code 0. Every local register reads back as 0x0000. The ratio decode shows the 25% setting (`legacy_shift_o`=2, `legacy_mute_o`=0).
- R2: A write to select 2 (master register) sets the master enable from data bit 7. This write is accepted whatever the master enable is. The other bits of the data are ignored. A read of select 2 returns the enable in bit 7 and zero in all other bits.
- R3: While the master enable is clear, writes to select 0 and select 1 change nothing. Stored fields keep the values they had before the unit was disabled.
- R4: Select 0 (routing register) holds the left volume in bits 2:0 and the right volume in bits 6:4. Bits 3 and 7 read as zero.
- R5: Routing bits 11:8 enable channels 1 to 4 on the left side, with bit 8 as channel 1. Bits 15:12 do the same for the right side. These bits drive `en_l_o` and `en_r_o`, with bit 0 of each port as channel 1.
- R6: Select 1 (ratio register) stores data bits 1:0 as the ratio code. A read returns that code in bits 1:0 and zero in bits 15:2.
- R7: Ratio code decode: code 0 gives shift 2 (25%), code 1 gives shift 1 (50%) and code 2 gives shift 0 (100%). For these three codes `legacy_mute_o` is 0. Code 3 gives `legacy_mute_o`=1 with shift 0.
- R8: A read of any select other than 0, 1 and 2 returns zero. Writes to those selects change no local register.
- R9: `ext_wr_o` is high in the same cycle as a write strobe only when both hold: the select is not 0, 1 or 2, and the master enable is set. Otherwise it is low.
- R10: A write takes effect at the rising clock edge where the strobe is high. Read data is combinational from `rd_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | ADDR_W | Register select for writes |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | ADDR_W | Register select for reads |
| rd_data_o | output | 16 | Formatted read data |
| master_en_o | output | 1 | Master enable |
| vol_l_o | output | 3 | Left volume |
| vol_r_o | output | 3 | Right volume |
| en_l_o | output | 4 | Left channel enables, bit 0 = channel 1 |
| en_r_o | output | 4 | Right channel enables, bit 0 = channel 1 |
| legacy_shift_o | output | 2 | Right-shift for the legacy channel mix |
| legacy_mute_o | output | 1 | Legacy channel mix muted |
| ext_wr_o | output | 1 | Gated write strobe to other sound registers |

## Verification
Stored fields and their decoded outputs are due one cycle after a write: they change at the edge that samples the strobe. Read data and `ext_wr_o` are due in the same cycle as their select or strobe.

Stimulus is driven on the falling edge. Each expected item is queued at the moment its stimulus is applied. The monitor pops queued items 2 ns after the next rising edge. By then a write has landed and a combinational read has settled, and no input is changing.

// File: rtl/snd_ctl_pkg.sv
package snd_ctl_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned NUM_CH     = 4;
  localparam int unsigned VOL_W      = 3;
  localparam int unsigned VOL_SLOT   = 4;
  localparam int unsigned RATIO_W    = 2;
  localparam int unsigned MASTER_BIT = 7;
  localparam int unsigned R_VOL_LSB  = VOL_SLOT;
  localparam int unsigned L_EN_LSB   = 2 * VOL_SLOT;
  localparam int unsigned R_EN_LSB   = L_EN_LSB + NUM_CH;

  localparam int unsigned ROUTE_IDX  = 0;
  localparam int unsigned RATIO_IDX  = 1;
  localparam int unsigned MASTER_IDX = 2;

  typedef enum logic [RATIO_W-1:0] {
    RATIO_QUARTER = 2'd0,
    RATIO_HALF    = 2'd1,
    RATIO_FULL    = 2'd2,
    RATIO_OFF     = 2'd3
  } ratio_e;

  typedef struct packed {
    logic route;
    logic ratio;
    logic master;
  } hit_t;
endpackage

// File: rtl/snd_ctl_decode.sv
module snd_ctl_decode
  import snd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] sel_i,
  output hit_t              hit_o,
  output logic              local_o
);
  always_comb begin
    hit_o.route  = (sel_i == ADDR_W'(ROUTE_IDX));
    hit_o.ratio  = (sel_i == ADDR_W'(RATIO_IDX));
    hit_o.master = (sel_i == ADDR_W'(MASTER_IDX));
    local_o      = hit_o.route | hit_o.ratio | hit_o.master;
  end
endmodule

// File: rtl/snd_ctl_regs.sv
module snd_ctl_regs
  import snd_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  hit_t              hit_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              master_o,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o,
  output logic [NUM_CH-1:0] en_l_o,
  output logic [NUM_CH-1:0] en_r_o,
  output ratio_e            ratio_o
);
  logic wr_master, wr_route, wr_ratio;

  // master register is always writable, the rest only while enabled
  assign wr_master = wr_en_i & hit_i.master;
  assign wr_route  = wr_en_i & hit_i.route & master_o;
  assign wr_ratio  = wr_en_i & hit_i.ratio & master_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_o <= 1'b0;
    end else if (wr_master) begin
      master_o <= wr_data_i[MASTER_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_l_o <= '0;
      vol_r_o <= '0;
    end else if (wr_route) begin
      vol_l_o <= wr_data_i[VOL_W-1:0];
      vol_r_o <= wr_data_i[R_VOL_LSB +: VOL_W];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_l_o[ch] <= 1'b0;
        en_r_o[ch] <= 1'b0;
      end else if (wr_route) begin
        en_l_o[ch] <= wr_data_i[L_EN_LSB + ch];
        en_r_o[ch] <= wr_data_i[R_EN_LSB + ch];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o <= RATIO_QUARTER;
    end else if (wr_ratio) begin
      ratio_o <= ratio_e'(wr_data_i[RATIO_W-1:0]);
    end
  end
endmodule

// File: rtl/snd_ctl_ratio_dec.sv
module snd_ctl_ratio_dec
  import snd_ctl_pkg::*;
(
  input  ratio_e     code_i,
  output logic [1:0] shift_o,
  output logic       mute_o
);
  always_comb begin
    shift_o = 2'd0;
    mute_o  = 1'b0;
    unique case (code_i)
      RATIO_QUARTER: shift_o = 2'd2;
      RATIO_HALF:    shift_o = 2'd1;
      RATIO_FULL:    shift_o = 2'd0;
      RATIO_OFF:     mute_o  = 1'b1;
      default:       mute_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/snd_ctl_rdfmt.sv
module snd_ctl_rdfmt
  import snd_ctl_pkg::*;
(
  input  hit_t              hit_i,
  input  logic              master_i,
  input  logic [VOL_W-1:0]  vol_l_i,
  input  logic [VOL_W-1:0]  vol_r_i,
  input  logic [NUM_CH-1:0] en_l_i,
  input  logic [NUM_CH-1:0] en_r_i,
  input  ratio_e            ratio_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (hit_i.route) begin
      rd_data_o[VOL_W-1:0]            = vol_l_i;
      rd_data_o[R_VOL_LSB +: VOL_W]   = vol_r_i;
      rd_data_o[L_EN_LSB +: NUM_CH]   = en_l_i;
      rd_data_o[R_EN_LSB +: NUM_CH]   = en_r_i;
    end
    if (hit_i.ratio) begin
      rd_data_o[RATIO_W-1:0]          = ratio_i;
    end
    if (hit_i.master) begin
      rd_data_o[MASTER_BIT]           = master_i;
    end
  end
endmodule

// File: rtl/snd_ctl_bank.sv
module snd_ctl_bank
  import snd_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_sel_i,
  input  logic [15:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_sel_i,
  output logic [15:0]       rd_data_o,
  output logic              master_en_o,
  output logic [2:0]        vol_l_o,
  output logic [2:0]        vol_r_o,
  output logic [3:0]        en_l_o,
  output logic [3:0]        en_r_o,
  output logic [1:0]        legacy_shift_o,
  output logic              legacy_mute_o,
  output logic              ext_wr_o
);
  hit_t   wr_hit, rd_hit;
  logic   wr_local, rd_local;
  ratio_e ratio_q;

  snd_ctl_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
    .sel_i   (wr_sel_i),
    .hit_o   (wr_hit),
    .local_o (wr_local)
  );

  snd_ctl_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
    .sel_i   (rd_sel_i),
    .hit_o   (rd_hit),
    .local_o (rd_local)
  );

  snd_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .hit_i     (wr_hit),
    .wr_data_i (wr_data_i),
    .master_o  (master_en_o),
    .vol_l_o   (vol_l_o),
    .vol_r_o   (vol_r_o),
    .en_l_o    (en_l_o),
    .en_r_o    (en_r_o),
    .ratio_o   (ratio_q)
  );

  snd_ctl_ratio_dec u_ratio (
    .code_i  (ratio_q),
    .shift_o (legacy_shift_o),
    .mute_o  (legacy_mute_o)
  );

  logic [15:0] rd_fmt;

  snd_ctl_rdfmt u_rdfmt (
    .hit_i     (rd_hit),
    .master_i  (master_en_o),
    .vol_l_i   (vol_l_o),
    .vol_r_i   (vol_r_o),
    .en_l_i    (en_l_o),
    .en_r_i    (en_r_o),
    .ratio_i   (ratio_q),
    .rd_data_o (rd_fmt)
  );

  assign rd_data_o = rd_local ? rd_fmt : 16'h0000;

  // forward only non-local writes, and only while enabled
  assign ext_wr_o = wr_en_i & master_en_o & ~wr_local;
endmodule

// File: rtl/snd_ctl_bank_chk.sv
module snd_ctl_bank_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_sel_i,
  input logic [15:0]       wr_data_i,
  input logic [ADDR_W-1:0] rd_sel_i,
  input logic [15:0]       rd_data_o,
  input logic              master_en_o,
  input logic [2:0]        vol_l_o,
  input logic [2:0]        vol_r_o,
  input logic [3:0]        en_l_o,
  input logic [3:0]        en_r_o,
  input logic [1:0]        legacy_shift_o,
  input logic              legacy_mute_o,
  input logic              ext_wr_o
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!master_en_o && vol_l_o == 3'd0 && vol_r_o == 3'd0
                               && en_l_o == 4'd0 && en_r_o == 4'd0);
    end
  end

  // R2
  master_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == ADDR_W'(2) |=> master_en_o == $past(wr_data_i[7]));

  // R3
  gated_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !master_en_o && wr_sel_i == ADDR_W'(0)
    |=> $stable({vol_l_o, vol_r_o, en_l_o, en_r_o}));

  // R3
  gated_ratio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !master_en_o && wr_sel_i == ADDR_W'(1)
    |=> $stable({legacy_shift_o, legacy_mute_o}));

  // R4
  vol_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && master_en_o && wr_sel_i == ADDR_W'(0)
    |=> vol_l_o == $past(wr_data_i[2:0]) && vol_r_o == $past(wr_data_i[6:4]));

  // R5
  route_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && master_en_o && wr_sel_i == ADDR_W'(0)
    |=> en_l_o == $past(wr_data_i[11:8]) && en_r_o == $past(wr_data_i[15:12]));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i > ADDR_W'(2) |-> rd_data_o == 16'h0000);

  // R9
  ext_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_o |-> wr_en_i && master_en_o && wr_sel_i > ADDR_W'(2));
endmodule

bind snd_ctl_bank snd_ctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_snd_ctl_bank.sv
`timescale 1ns/1ps
module tb_snd_ctl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        master_en, legacy_mute, ext_wr;
  logic [2:0]  vol_l, vol_r;
  logic [3:0]  en_l, en_r;
  logic [1:0]  legacy_shift;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  snd_ctl_bank #(.ADDR_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .master_en_o(master_en), .vol_l_o(vol_l), .vol_r_o(vol_r),
    .en_l_o(en_l), .en_r_o(en_r), .legacy_shift_o(legacy_shift),
    .legacy_mute_o(legacy_mute), .ext_wr_o(ext_wr)
  );

  function automatic logic [31:0] pk(input logic m, input logic [2:0] vl,
      input logic [2:0] vr, input logic [3:0] el, input logic [3:0] er,
      input logic [1:0] sh, input logic mu);
    return {14'd0, m, vl, vr, el, er, sh, mu};
  endfunction

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [3:0] s, input logic [15:0] e, input string tag);
    @(negedge clk);
    rd_sel = s;
    q.push_back('{0, {16'd0, e}, tag});
  endtask

  task automatic exp_out(input logic [31:0] e, input string tag);
    @(negedge clk);
    q.push_back('{1, e, tag});
  endtask

  task automatic exp_ext(input logic [3:0] s, input logic [15:0] d, input logic e,
                         input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    q.push_back('{2, {31'd0, e}, tag});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: compares queued items just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = {16'd0, rd_data};
          1:       act = pk(master_en, vol_l, vol_r, en_l, en_r, legacy_shift, legacy_mute);
          default: act = {31'd0, ext_wr};
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R10 actual=hang expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    exp_rd(4'd0, 16'h0000, "R1 route reset");
    exp_rd(4'd1, 16'h0000, "R1 ratio reset");
    exp_rd(4'd2, 16'h0000, "R1 master reset");
    exp_out(pk(0, 0, 0, 0, 0, 2, 0), "R1 outputs reset");

    wr(4'd0, 16'hFFFF);
    wr(4'd1, 16'h0003);
    exp_rd(4'd0, 16'h0000, "R3 route write while off");
    exp_rd(4'd1, 16'h0000, "R3 ratio write while off");
    exp_out(pk(0, 0, 0, 0, 0, 2, 0), "R3 outputs while off");
    exp_ext(4'd5, 16'h1234, 1'b0, "R9 ext write while off");

    wr(4'd2, 16'hFF7F);
    exp_rd(4'd2, 16'h0000, "R2 bit7 clear");
    wr(4'd2, 16'hFFFF);
    exp_rd(4'd2, 16'h0080, "R2 only bit7 kept");
    exp_out(pk(1, 0, 0, 0, 0, 2, 0), "R2 master on");

    wr(4'd0, 16'h9A35);
    exp_rd(4'd0, 16'h9A35, "R10 route readback next cycle");
    exp_out(pk(1, 5, 3, 4'hA, 4'h9, 2, 0), "R5 route fields");
    wr(4'd0, 16'hFFFF);
    exp_rd(4'd0, 16'hFF77, "R4 reserved bits zero");
    exp_out(pk(1, 7, 7, 4'hF, 4'hF, 2, 0), "R4 full volumes");
    wr(4'd0, 16'h0100);
    exp_out(pk(1, 0, 0, 4'h1, 4'h0, 2, 0), "R5 channel 1 left");
    wr(4'd0, 16'h8000);
    exp_out(pk(1, 0, 0, 4'h0, 4'h8, 2, 0), "R5 channel 4 right");
    wr(4'd0, 16'h0100);

    wr(4'd1, 16'hFFFC);
    exp_rd(4'd1, 16'h0000, "R6 code 0 upper ignored");
    exp_out(pk(1, 0, 0, 1, 0, 2, 0), "R7 quarter");
    wr(4'd1, 16'h0001);
    exp_rd(4'd1, 16'h0001, "R6 code 1");
    exp_out(pk(1, 0, 0, 1, 0, 1, 0), "R7 half");
    wr(4'd1, 16'h0002);
    exp_rd(4'd1, 16'h0002, "R6 code 2");
    exp_out(pk(1, 0, 0, 1, 0, 0, 0), "R7 full");
    wr(4'd1, 16'hFFFF);
    exp_rd(4'd1, 16'h0003, "R6 code 3");
    exp_out(pk(1, 0, 0, 1, 0, 0, 1), "R7 mute");

    exp_rd(4'd3, 16'h0000, "R8 select 3 reads zero");
    exp_rd(4'd9, 16'h0000, "R8 select 9 reads zero");
    wr(4'd3, 16'hFFFF);
    exp_rd(4'd3, 16'h0000, "R8 select 3 after write");
    exp_rd(4'd0, 16'h0100, "R8 route untouched");
    exp_out(pk(1, 0, 0, 1, 0, 0, 1), "R8 outputs untouched");

    exp_ext(4'd6, 16'hAAAA, 1'b1, "R9 ext write forwarded");
    exp_ext(4'd2, 16'h0080, 1'b0, "R9 master write local");
    exp_ext(4'd0, 16'h0100, 1'b0, "R9 route write local");

    wr(4'd2, 16'h0000);
    exp_out(pk(0, 0, 0, 1, 0, 0, 1), "R3 fields kept on disable");
    wr(4'd0, 16'hFFFF);
    exp_rd(4'd0, 16'h0100, "R3 route kept while off");
    wr(4'd1, 16'h0000);
    exp_rd(4'd1, 16'h0003, "R3 ratio kept while off");
    exp_ext(4'd7, 16'h0001, 1'b0, "R9 ext suppressed after disable");

    wr(4'd2, 16'h0080);
    exp_rd(4'd2, 16'h0080, "R2 re-enable");
    wr(4'd0, 16'h0F00);
    exp_rd(4'd0, 16'h0F00, "R10 write after re-enable");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule